// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block runs the pulse-and-verify programming loop for a byte-wide flash device from the host side. On a start request it programs every location from address zero up to a given last address. For each byte it sends the device a program-setup opcode and then the address with the data byte. It waits out a program pulse and sends a verify opcode. After a settle time it reads the location back and compares the result with the data it wanted to store.

A byte that reads back wrong gets another full attempt. The attempt count restarts for every byte and is capped at a fixed maximum of twenty by default. When a byte uses up its attempts, the run stops and reports the failing address. The bytes to be written come from a data source port that is indexed by the sequencer's current address. Device traffic goes out as single bus-cycle requests, each held until the bus side acknowledges it. The supply voltage and the electrical bus timing are handled outside this block. Both waits are parameters counted in clock cycles, so the integrator sets them from the clock frequency.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, busy, done, fail and bus_req are all low, and fail_addr is zero.
- R2: A start pulse seen while idle raises busy on the next clock edge. The run begins at address 0 with a zero attempt count, and its first request is a write of data 40h.
- R3: Every attempt issues four requests in this fixed order: a write of 40h, a write of the target address with its source byte, a write of C0h, and then a read of the target address.
- R4: After the program write is acknowledged, bus_req stays low for exactly PULSE_CYC cycles before the C0h write. After the C0h write is acknowledged, bus_req stays low for exactly VERIFY_CYC cycles before the read.
- R5: When the read-back equals the source byte at the last address, busy falls and done rises. When it matches at any other address, the sequencer moves to the next address with a fresh attempt count.
- R6: When the read-back differs and fewer than MAX_TRIES attempts have been made on the byte, the sequencer repeats the whole attempt on the same address. A byte that takes exactly MAX_TRIES pulses therefore still succeeds.
- R7: A mismatch on attempt MAX_TRIES ends the run. fail rises, fail_addr gives the byte's address, busy falls, and no further bus requests are issued.
- R8: done, fail and fail_addr hold their values while idle until the next start, and the start clears them. done and fail are never high together.
- R9: A start pulse while busy has no effect on the run in progress.
- R10: While bus_req is high and not acknowledged, bus_we, bus_addr and bus_wdata stay stable and bus_req stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (honoured only when idle) |
| last_addr | input | ADDR_W | Highest address to program; captured at start |
| src_addr | output | ADDR_W | Address of the byte wanted from the data source |
| src_data | input | DATA_W | Source byte for src_addr |
| bus_req | output | 1 | Bus-cycle request, held until acknowledged |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | ADDR_W | Device address of the cycle |
| bus_wdata | output | DATA_W | Write data (opcode or program byte) |
| bus_ack | input | 1 | Completes the pending cycle |
| bus_rdata | input | DATA_W | Read data, valid together with bus_ack on a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished with all bytes verified |
| fail | output | 1 | Last run stopped on a byte that would not verify |
| fail_addr | output | ADDR_W | Address of the byte that failed |

## Verification
A corrupted attempt counter or address register shows up at the ports within a single attempt. It appears as a retry on the wrong address, a skipped byte in the order of program writes, or a byte that fails one pulse early or late against the twenty-pulse limit. A corrupted wait timer shows up as a low gap on bus_req of the wrong length, measured on the next pulse or settle wait. A lost step in the state sequence breaks the fixed four-request order of an attempt, and that is visible on the very next request.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PROG,
        ST_PWAIT,
        ST_VCMD,
        ST_VWAIT,
        ST_VREAD
    } seq_state_e;

    localparam logic [7:0] OPC_PROG_SETUP = 8'h40;
    localparam logic [7:0] OPC_PROG_CHECK = 8'hC0;

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // Loaded value appears one cycle after the load request (wait length, R4)
    assert_timer_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    // Counter only steps down by one when not reloaded (R4)
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/flash_seq_busenc.sv
module flash_seq_busenc
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_data,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    localparam logic [DATA_W-1:0] SETUP_WORD = DATA_W'(OPC_PROG_SETUP);
    localparam logic [DATA_W-1:0] CHECK_WORD = DATA_W'(OPC_PROG_CHECK);

    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = cur_addr;
        wdata = '0;
        case (state)
            ST_SETUP: begin
                req   = 1'b1;
                we    = 1'b1;
                wdata = SETUP_WORD;
            end
            ST_PROG: begin
                req   = 1'b1;
                we    = 1'b1;
                wdata = cur_data;
            end
            ST_VCMD: begin
                req   = 1'b1;
                we    = 1'b1;
                wdata = CHECK_WORD;
            end
            ST_VREAD: begin
                req   = 1'b1;
                we    = 1'b0;
            end
            default: begin
                req   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 1250,
    parameter int VERIFY_CYC = 300,
    parameter int MAX_TRIES  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);

    localparam int TMAX  = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TMR_W-1:0] PULSE_LOAD  = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] VERIFY_LOAD = TMR_W'(VERIFY_CYC - 1);
    localparam logic [TRY_W-1:0] LAST_TRY    = TRY_W'(MAX_TRIES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] last;
        logic [TRY_W-1:0]  tries;
        logic              done;
        logic              fail;
        logic [ADDR_W-1:0] fail_addr;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rd_match;

    assign rd_match = (bus_rdata == src_data);

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state     = ST_SETUP;
                    r_d.addr      = '0;
                    r_d.last      = last_addr;
                    r_d.tries     = '0;
                    r_d.done      = 1'b0;
                    r_d.fail      = 1'b0;
                    r_d.fail_addr = '0;
                end
            end
            ST_SETUP: begin
                if (bus_ack) r_d.state = ST_PROG;
            end
            ST_PROG: begin
                if (bus_ack) begin
                    r_d.state = ST_PWAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = PULSE_LOAD;
                end
            end
            ST_PWAIT: begin
                if (tmr_expired) r_d.state = ST_VCMD;
            end
            ST_VCMD: begin
                if (bus_ack) begin
                    r_d.state = ST_VWAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = VERIFY_LOAD;
                end
            end
            ST_VWAIT: begin
                if (tmr_expired) r_d.state = ST_VREAD;
            end
            ST_VREAD: begin
                if (bus_ack) begin
                    if (rd_match) begin
                        if (r_q.addr == r_q.last) begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.state = ST_SETUP;
                            r_d.addr  = r_q.addr + 1'b1;
                            r_d.tries = '0;
                        end
                    end else if (r_q.tries == LAST_TRY) begin
                        r_d.state     = ST_IDLE;
                        r_d.fail      = 1'b1;
                        r_d.fail_addr = r_q.addr;
                    end else begin
                        r_d.state = ST_SETUP;
                        r_d.tries = r_q.tries + 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.addr      <= '0;
            r_q.last      <= '0;
            r_q.tries     <= '0;
            r_q.done      <= 1'b0;
            r_q.fail      <= 1'b0;
            r_q.fail_addr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    flash_seq_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    flash_seq_busenc #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_busenc (
        .state    (r_q.state),
        .cur_addr (r_q.addr),
        .cur_data (src_data),
        .req      (bus_req),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata)
    );

    assign src_addr  = r_q.addr;
    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign fail_addr = r_q.fail_addr;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && src_addr == '0 && !done && !fail));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                                   $stable(bus_addr) && $stable(bus_wdata)));

    assert_tries_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.tries < TRY_W'(MAX_TRIES)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(done) && $stable(fail) && $stable(fail_addr)));

    assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !bus_ack) |=> $stable(src_addr));

endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int PC  = 7;
    localparam int VC  = 3;
    localparam int MT  = 20;
    localparam int NB  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [AW-1:0] src_addr;
    logic [DW-1:0] src_data;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // flash model state
    int          need   [NB];
    int          pulses [NB];
    logic [DW-1:0] mem  [NB];
    int phase, proto_err, setups, gap, bad_pgap, bad_vgap, idle_reqs, prog_order_err;
    int prog_addr, next_expect;
    logic prev_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign src_data = 8'hA0 | {4'h0, src_addr};

    flash_prog_seq #(
        .ADDR_W (AW), .DATA_W (DW), .PULSE_CYC (PC),
        .VERIFY_CYC (VC), .MAX_TRIES (MT)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start (start), .last_addr (last_addr),
        .src_addr (src_addr), .src_data (src_data),
        .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_ack (bus_ack), .bus_rdata (bus_rdata),
        .busy (busy), .done (done), .fail (fail), .fail_addr (fail_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NB; i++) begin
            need[i] = 1; pulses[i] = 0; mem[i] = 8'hFF;
        end
        phase = 0; proto_err = 0; setups = 0; bad_pgap = 0; bad_vgap = 0;
        idle_reqs = 0; prog_order_err = 0; next_expect = 0;
    endtask

    // bus-side flash model, acts on falling edges
    initial begin
        prev_req = 1'b0; gap = 0;
        clear_model();
        forever begin
            @(negedge clk);
            if (bus_req && !busy) idle_reqs++;
            if (bus_req && !prev_req) begin
                if (phase == 2 && gap != PC) bad_pgap++;
                if (phase == 3 && gap != VC) bad_vgap++;
            end
            if (bus_req) gap = 0; else gap++;
            prev_req = bus_req;
            if (bus_req && !bus_ack) begin
                bus_ack = 1'b1;
                if (bus_we && bus_wdata == 8'h40 && phase == 0) begin
                    setups++; phase = 1;
                end else if (bus_we && phase == 1) begin
                    prog_addr = int'(bus_addr);
                    if (prog_addr != next_expect && prog_addr != next_expect - 1) prog_order_err++;
                    next_expect = prog_addr + 1;
                    pulses[prog_addr]++;
                    if (pulses[prog_addr] >= need[prog_addr]) mem[prog_addr] = bus_wdata;
                    phase = 2;
                end else if (bus_we && bus_wdata == 8'hC0 && phase == 2) begin
                    phase = 3;
                end else if (!bus_we && phase == 3) begin
                    if (int'(bus_addr) != prog_addr) proto_err++;
                    bus_rdata = mem[prog_addr];
                    phase = 0;
                end else begin
                    proto_err++;
                end
            end else begin
                bus_ack = 1'b0;
            end
        end
    end

    task automatic pulse_start(input logic [AW-1:0] last);
        @(negedge clk);
        last_addr = last;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic test_reset();
        check(!busy && !done && !fail && !bus_req, "R1 idle outputs", int'({busy,done,fail,bus_req}), 0);
        check(fail_addr == '0, "R1 fail_addr", int'(fail_addr), 0);
    endtask

    task automatic test_basic();
        clear_model();
        @(negedge clk);
        last_addr = 4'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        check(bus_req && bus_we && bus_wdata == 8'h40 && src_addr == 0,
              "R2 first request 40h at addr 0", int'(bus_wdata), 8'h40);
        wait_idle();
        check(done && !fail, "R5 done after last byte", int'({done,fail}), 2);
        check(proto_err == 0, "R3 request order", proto_err, 0);
        check(prog_order_err == 0, "R5 address order", prog_order_err, 0);
        for (int i = 0; i < 4; i++)
            check(mem[i] == (8'hA0 | i[7:0]) && pulses[i] == 1, "R5 byte programmed once",
                  int'(mem[i]), int'(8'hA0 | i[7:0]));
        check(pulses[4] == 0, "R5 no write past last", pulses[4], 0);
    endtask

    task automatic test_timing();
        check(bad_pgap == 0, "R4 pulse wait length", bad_pgap, 0);
        check(bad_vgap == 0, "R4 verify wait length", bad_vgap, 0);
    endtask

    task automatic test_retry();
        clear_model();
        need[0] = 5; need[1] = MT; need[2] = MT - 1; need[3] = 2;
        pulse_start(4'd3);
        wait_idle();
        check(done && !fail, "R6 retries then done", int'({done,fail}), 2);
        check(pulses[0] == 5, "R6 pulses on byte 0", pulses[0], 5);
        check(pulses[1] == MT, "R6 exactly MAX_TRIES pulses succeed", pulses[1], MT);
        check(pulses[2] == MT - 1, "R5 counter fresh per byte", pulses[2], MT - 1);
        check(setups == 5 + MT + MT - 1 + 2, "R3 one setup per attempt", setups, 5 + MT + MT - 1 + 2);
        check(proto_err == 0 && bad_pgap == 0 && bad_vgap == 0, "R4 order and waits in retries",
              proto_err + bad_pgap + bad_vgap, 0);
    endtask

    task automatic test_fail();
        clear_model();
        need[2] = MT + 1;
        pulse_start(4'd5);
        check(!done && !fail, "R8 start clears result", int'({done,fail}), 0);
        wait_idle();
        check(fail && !done, "R7 fail flag", int'({done,fail}), 1);
        check(fail_addr == 4'd2, "R7 fail address", int'(fail_addr), 2);
        check(pulses[2] == MT, "R7 attempts before fail", pulses[2], MT);
        check(pulses[3] == 0, "R7 nothing after failing byte", pulses[3], 0);
        repeat (30) @(negedge clk);
        check(idle_reqs == 0 && !bus_req, "R7 quiet after fail", idle_reqs, 0);
        check(fail && fail_addr == 4'd2 && !done, "R8 fail result held", int'(fail_addr), 2);
    endtask

    task automatic test_start_busy();
        clear_model();
        for (int i = 0; i < 4; i++) need[i] = 2;
        pulse_start(4'd3);
        repeat (25) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (13) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check(done && !fail, "R9 run completes", int'({done,fail}), 2);
        check(setups == 8, "R9 start while busy ignored", setups, 8);
        check(prog_order_err == 0, "R9 no restart at 0", prog_order_err, 0);
        repeat (20) @(negedge clk);
        check(done && !fail, "R8 done held while idle", int'({done,fail}), 2);
    endtask

    task automatic test_single();
        clear_model();
        need[0] = 3;
        pulse_start(4'd0);
        wait_idle();
        check(done && pulses[0] == 3 && pulses[1] == 0, "R5 single byte range", pulses[0], 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_timing();
        test_retry();
        test_fail();
        test_start_busy();
        test_single();
        check(proto_err == 0, "R10 handshake protocol", proto_err, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule